// File: doc/BRIEF.md
# Position-Dependent Instruction Length Decoder

This block takes a 64-bit fetch block made of four 16-bit units and splits it into instructions. Each instruction is 16, 32, 48 or 64 bits long. The length is set by two things: the opcode class in the first unit of the instruction, and the unit position where that instruction begins. No instruction may run past the end of the block. When an opcode of a long class begins too late to fit, it is decoded as a shorter form, or as an alternate 16-bit form, and a reduced-form flag marks that record.

The decoder scans from unit 0. Each instruction begins at the unit after the end of the one before it. The decoder produces up to four records, one for each instruction in the order they appear. Every record carries a valid bit, the start unit, a length code and the reduced-form flag. The decode itself is combinational. The records are registered, and an input strobe gives an output strobe one cycle later, so an instruction-steering stage can take one record set per accepted block.

Top module: `ild_decoder`

## Requirements
- R1: Unit k of `in_block` sits in bits [16k+15:16k]. Bits [15:13] of a unit select its class: 0xx gives the half class, 100 the word class, 101 the flex class, 110 the triple class and 111 the quad class. The other bits of the unit have no effect on the decode.
- R2: Length codes are 0 for 16 bits, 1 for 32 bits, 2 for 48 bits and 3 for 64 bits. A half-class unit is always decoded as 16 bits with the reduced flag at 0.
- R3: A word-class opcode is decoded as 32 bits at units 0, 1 and 2. At unit 3 it is decoded as 16 bits with the reduced flag at 1.
- R4: A flex-class opcode is decoded as 32 bits at units 0 and 2 and as 48 bits at unit 1, in each case with the reduced flag at 0. At unit 3 it is decoded as 16 bits with the reduced flag at 1.
- R5: A triple-class opcode is decoded as 48 bits at units 0 and 1 with the reduced flag at 0. At unit 2 it becomes 32 bits and at unit 3 it becomes 16 bits, both with the reduced flag at 1.
- R6: A quad-class opcode is decoded as 64 bits only at unit 0. At unit 1 it becomes 48 bits, at unit 2 it becomes 32 bits and at unit 3 it becomes 16 bits, each with the reduced flag at 1.
- R7: Record 0 starts at unit 0. Each following record starts at the previous start plus the previous length in units. The valid records are contiguous from record 0, and together they cover exactly the four units. Records past the last instruction have valid, start, length and flag all at 0. Record i uses bits [2i+1:2i] of `rec_start` and `rec_len`, and bit i of `rec_valid` and `rec_reduced`.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. The records change only after an accepted block. While `in_valid` is low they keep their values.
- R9: While `rst` is high, `out_valid` and every record field read 0.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch block present this cycle |
| in_block | input | 64 | Four 16-bit units, unit 0 in the low bits |
| out_valid | output | 1 | Records belong to the block accepted last cycle |
| rec_valid | output | 4 | Record present, bit i for record i |
| rec_start | output | 8 | Start unit, 2 bits per record |
| rec_len | output | 8 | Length code, 2 bits per record |
| rec_reduced | output | 4 | Shortened or alternate decode, bit i for record i |

## Verification
The assertions check structural rules of the registered records on every cycle. These rules are: record 0 at unit 0, starts that follow each other in a chain, contiguous valid bits, coverage of exactly four units, no 64-bit length after record 0, the one-cycle strobe latency and the hold of the records. Only the bench's scenarios can show that each class gets the correct length and flag at each start position. To do this, the bench places every class at every unit behind runs of half-class units, then runs random blocks with random strobes and compares against its own model, which is based on the room left in the block.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef enum logic [2:0] {
    CLS_HALF   = 3'd0,
    CLS_WORD   = 3'd1,
    CLS_FLEX   = 3'd2,
    CLS_TRIPLE = 3'd3,
    CLS_QUAD   = 3'd4
  } op_class_t;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_32 = 2'd1,
    LEN_48 = 2'd2,
    LEN_64 = 2'd3
  } len_code_t;

  typedef struct packed {
    len_code_t len;
    logic      reduced;
  } pos_rule_t;
endpackage

// File: rtl/ild_unit_class.sv
module ild_unit_class
  import ild_pkg::*;
#(
  parameter int UNIT_W = 16
) (
  input  logic [UNIT_W-1:0] unit_bits,
  output op_class_t         cls
);
  localparam int TOP = UNIT_W - 1;

  always_comb begin
    if (!unit_bits[TOP]) cls = CLS_HALF;
    else begin
      unique case (unit_bits[TOP-1:TOP-2])
        2'b00:   cls = CLS_WORD;
        2'b01:   cls = CLS_FLEX;
        2'b10:   cls = CLS_TRIPLE;
        default: cls = CLS_QUAD;
      endcase
    end
  end
endmodule

// File: rtl/ild_pos_rule.sv
module ild_pos_rule
  import ild_pkg::*;
#(
  parameter int POS = 0
) (
  input  op_class_t cls,
  output pos_rule_t rule
);
  always_comb begin
    rule = '{len: LEN_16, reduced: 1'b0};
    unique case (cls)
      CLS_HALF: rule = '{len: LEN_16, reduced: 1'b0};
      CLS_WORD: begin
        if (POS == 3) rule = '{len: LEN_16, reduced: 1'b1};
        else          rule = '{len: LEN_32, reduced: 1'b0};
      end
      CLS_FLEX: begin
        if (POS == 3)      rule = '{len: LEN_16, reduced: 1'b1};
        else if (POS == 1) rule = '{len: LEN_48, reduced: 1'b0};
        else               rule = '{len: LEN_32, reduced: 1'b0};
      end
      CLS_TRIPLE: begin
        if (POS == 3)      rule = '{len: LEN_16, reduced: 1'b1};
        else if (POS == 2) rule = '{len: LEN_32, reduced: 1'b1};
        else               rule = '{len: LEN_48, reduced: 1'b0};
      end
      default: begin
        if (POS == 3)      rule = '{len: LEN_16, reduced: 1'b1};
        else if (POS == 2) rule = '{len: LEN_32, reduced: 1'b1};
        else if (POS == 1) rule = '{len: LEN_48, reduced: 1'b1};
        else               rule = '{len: LEN_64, reduced: 1'b0};
      end
    endcase
  end
endmodule

// File: rtl/ild_scan.sv
module ild_scan
  import ild_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  localparam int PW = $clog2(NUM_UNITS)
) (
  input  pos_rule_t              rule_at [NUM_UNITS],
  output logic [NUM_UNITS-1:0]   nxt_valid,
  output logic [NUM_UNITS*PW-1:0] nxt_start,
  output logic [NUM_UNITS*PW-1:0] nxt_len,
  output logic [NUM_UNITS-1:0]   nxt_reduced
);
  always_comb begin
    logic [PW:0] pos;
    nxt_valid   = '0;
    nxt_start   = '0;
    nxt_len     = '0;
    nxt_reduced = '0;
    pos         = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (pos < (PW+1)'(NUM_UNITS)) begin
        nxt_valid[i]          = 1'b1;
        nxt_start[i*PW +: PW] = pos[PW-1:0];
        nxt_len[i*PW +: PW]   = PW'(rule_at[pos[PW-1:0]].len);
        nxt_reduced[i]        = rule_at[pos[PW-1:0]].reduced;
        pos = pos + (PW+1)'(rule_at[pos[PW-1:0]].len) + (PW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/ild_decoder.sv
module ild_decoder
  import ild_pkg::*;
#(
  parameter int UNIT_W = 16,
  localparam int NUM_UNITS = 4,
  localparam int PW = 2,
  localparam int BLOCK_W = UNIT_W * NUM_UNITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [BLOCK_W-1:0]      in_block,
  output logic                    out_valid,
  output logic [NUM_UNITS-1:0]    rec_valid,
  output logic [NUM_UNITS*PW-1:0] rec_start,
  output logic [NUM_UNITS*PW-1:0] rec_len,
  output logic [NUM_UNITS-1:0]    rec_reduced
);
  op_class_t cls_at  [NUM_UNITS];
  pos_rule_t rule_at [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ild_unit_class #(.UNIT_W(UNIT_W)) i_cls (
      .unit_bits(in_block[u*UNIT_W +: UNIT_W]),
      .cls      (cls_at[u])
    );
    ild_pos_rule #(.POS(u)) i_rule (
      .cls (cls_at[u]),
      .rule(rule_at[u])
    );
  end

  logic [NUM_UNITS-1:0]    nxt_valid;
  logic [NUM_UNITS*PW-1:0] nxt_start;
  logic [NUM_UNITS*PW-1:0] nxt_len;
  logic [NUM_UNITS-1:0]    nxt_reduced;

  ild_scan #(.NUM_UNITS(NUM_UNITS)) i_scan (
    .rule_at    (rule_at),
    .nxt_valid  (nxt_valid),
    .nxt_start  (nxt_start),
    .nxt_len    (nxt_len),
    .nxt_reduced(nxt_reduced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      rec_valid   <= '0;
      rec_start   <= '0;
      rec_len     <= '0;
      rec_reduced <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rec_valid   <= nxt_valid;
        rec_start   <= nxt_start;
        rec_len     <= nxt_len;
        rec_reduced <= nxt_reduced;
      end
    end
  end

  // Units covered by the registered records.
  logic [PW+1:0] covered;
  always_comb begin
    covered = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (rec_valid[i]) covered = covered + (PW+2)'(rec_len[i*PW +: PW]) + (PW+2)'(1);
  end

  AST_STROBE_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(rec_valid) && $stable(rec_start) && $stable(rec_len) && $stable(rec_reduced))); // R8
  AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rec_valid[0] && rec_start[PW-1:0] == '0)); // R7
  AST_FULL_COVER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> covered == (PW+2)'(NUM_UNITS)); // R7
  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((rec_valid & (rec_valid + 1'b1)) == '0)); // R7

  for (genvar i = 1; i < NUM_UNITS; i++) begin : g_chk
    AST_START_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (out_valid && rec_valid[i]) |->
        rec_start[i*PW +: PW] == PW'(rec_start[(i-1)*PW +: PW] + rec_len[(i-1)*PW +: PW] + 1'b1)); // R7
    AST_QUAD_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> rec_len[i*PW +: PW] != PW'(LEN_64)); // R6
  end
endmodule

// File: tb/test_ild_decoder.sv
module test_ild_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_block = '0;
  logic        out_valid;
  logic [3:0]  rec_valid, rec_reduced;
  logic [7:0]  rec_start, rec_len;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  ild_decoder i_ild_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
    .out_valid(out_valid), .rec_valid(rec_valid), .rec_start(rec_start),
    .rec_len(rec_len), .rec_reduced(rec_reduced)
  );

  // Reference model: natural size in units, cut to the room left in the block.
  logic        exp_ov = 1'b0;
  logic [3:0]  exp_v = '0, exp_r = '0;
  logic [7:0]  exp_s = '0, exp_l = '0;
  logic [63:0] exp_blk = '0;

  task automatic ref_model(input logic [63:0] blk, output logic [3:0] v,
                           output logic [7:0] s, output logic [7:0] l, output logic [3:0] r);
    int p = 0;
    int k = 0;
    v = '0; s = '0; l = '0; r = '0;
    while (p < 4) begin
      logic [2:0] top = blk[16*p+15 -: 3];
      int nat;
      int units;
      if (!top[2]) nat = 1;
      else if (top == 3'b100) nat = 2;
      else if (top == 3'b101) nat = (p == 1) ? 3 : 2;
      else if (top == 3'b110) nat = 3;
      else nat = 4;
      units = (nat > 4 - p) ? 4 - p : nat;
      v[k] = 1'b1;
      s[2*k +: 2] = 2'(p);
      l[2*k +: 2] = 2'(units - 1);
      r[k] = (units != nat);
      p += units;
      k++;
    end
  endtask

  always @(posedge clk) begin
    logic [3:0] nv, nr;
    logic [7:0] ns, nl;
    if (rst) begin
      exp_ov <= 1'b0; exp_v <= '0; exp_s <= '0; exp_l <= '0; exp_r <= '0;
    end else begin
      exp_ov <= in_valid;
      if (in_valid) begin
        ref_model(in_block, nv, ns, nl, nr);
        exp_v <= nv; exp_s <= ns; exp_l <= nl; exp_r <= nr; exp_blk <= in_block;
      end
    end
  end

  function automatic string len_tag(input logic [63:0] blk, input logic [1:0] p);
    logic [2:0] top = blk[16*p+15 -: 3];
    if (!top[2]) return "R1/R2";
    if (top == 3'b100) return "R1/R3";
    if (top == 3'b101) return "R1/R4";
    if (top == 3'b110) return "R1/R5";
    return "R1/R6";
  endfunction

  // Compared on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_ov) begin
        failures++;
        $display("FAIL %s out_valid actual=%b expected=%b", rst ? "R9" : "R8", out_valid, exp_ov);
      end
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (rec_valid[i] !== exp_v[i] || rec_start[2*i +: 2] !== exp_s[2*i +: 2]) begin
          failures++;
          $display("FAIL %s rec%0d valid/start actual=%b/%0d expected=%b/%0d",
                   rst ? "R9" : "R7", i, rec_valid[i], rec_start[2*i +: 2], exp_v[i], exp_s[2*i +: 2]);
        end else if (rec_len[2*i +: 2] !== exp_l[2*i +: 2] || rec_reduced[i] !== exp_r[i]) begin
          failures++;
          $display("FAIL %s rec%0d len/reduced actual=%0d/%b expected=%0d/%b",
                   rst ? "R9" : (exp_v[i] ? len_tag(exp_blk, exp_s[2*i +: 2]) : "R7"),
                   i, rec_len[2*i +: 2], rec_reduced[i], exp_l[2*i +: 2], exp_r[i]);
        end
      end
    end
  end

  task automatic send(input logic [63:0] blk, input logic v);
    @(negedge clk);
    in_block = blk;
    in_valid = v;
  endtask

  function automatic logic [15:0] mk_unit(input int cls, input logic [12:0] fill);
    logic [2:0] top;
    case (cls)
      0: top = 3'b011; 1: top = 3'b100; 2: top = 3'b101; 3: top = 3'b110; default: top = 3'b111;
    endcase
    return {top, fill};
  endfunction

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state is compared on each falling edge while rst is high
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2..R6: every class at every start unit, with half-class units before it
    for (int c = 0; c < 5; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [63:0] b;
        for (int u = 0; u < 4; u++) b[16*u +: 16] = mk_unit(0, 13'(u * 37 + c));
        b[16*p +: 16] = mk_unit(c, 13'h1abc);
        send(b, 1'b1);
      end
    end
    // R8: idle strobe with a different block must leave the records untouched
    send({4{mk_unit(4, 13'h0)}}, 1'b0);
    send({4{mk_unit(2, 13'h5)}}, 1'b0);
    // R7: mixed chains
    send({mk_unit(0, 0), mk_unit(2, 0), mk_unit(2, 0), mk_unit(0, 0)}, 1'b1);
    send({mk_unit(3, 0), mk_unit(1, 0), mk_unit(3, 0), mk_unit(4, 0)}, 1'b1);
    send({4{mk_unit(1, 13'h1fff)}}, 1'b1);
    // R1: random blocks and random strobes
    for (int n = 0; n < 400; n++) send({$urandom, $urandom}, 1'($urandom % 4 != 0));
    // R9: reset in mid-stream
    send({4{mk_unit(3, 0)}}, 1'b1);
    rst = 1'b1;
    send('0, 1'b1);
    send('0, 1'b0);
    rst = 1'b0;
    send({4{mk_unit(0, 0)}}, 1'b1);
    send('0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule